// File: doc/BRIEF.md
# Next Program Counter Selector

This block forms the program counter value for the following instruction whenever a control transfer may occur. A decode stage presents the current word address, a transfer strobe, a two-bit transfer kind and every candidate operand: an immediate target, the 16-bit Z pointer, an extension byte and a signed 12-bit displacement. On each rising clock edge the block registers the chosen address, so the new value appears one cycle after its inputs are sampled.

Addresses are 22-bit word addresses, and each word holds 16 bits. When the strobe is low, the block steps to the next word. When the strobe is high, the transfer kind selects one of four targets. The first is the immediate address. The second is Z, zero-extended above bit 15. The third places the extension byte above Z and keeps the low 22 bits. The fourth is the current address plus the signed displacement plus one. All arithmetic wraps modulo 2^22. The block does not decode instructions and does not stack return addresses.

Top module: `npc_sel`

## Requirements
- R1: When `rst_n` is low at a rising edge, `next_pc` becomes 0 at that edge, whatever the other inputs are.
- R2: When `xfer_en` is low, `next_pc` becomes `cur_pc + 1` modulo 2^22, so 0x3FFFFF steps to 0.
- R3: With `xfer_en` high and `xfer_kind` = 2'b00 (absolute), `next_pc` becomes `imm_tgt`.
- R4: With `xfer_en` high and `xfer_kind` = 2'b01 (indirect), `next_pc` becomes `z_ptr` in bits 15:0, with zeros in bits 21:16.
- R5: With `xfer_en` high and `xfer_kind` = 2'b10 (extended indirect), `next_pc` becomes `z_ptr` in bits 15:0 and `ext_hi[5:0]` in bits 21:16. `ext_hi[7:6]` has no effect.
- R6: With `xfer_en` high and `xfer_kind` = 2'b11 (relative), `next_pc` becomes `cur_pc + k + 1` modulo 2^22, where k is `rel_ofs` read as a signed value.
- R7: `rel_ofs` is a 12-bit two's-complement field covering -2048 to 2047. 12'h800 moves the address back by 2047, and 12'h7FF moves it forward by 2048.
- R8: When `xfer_en` is low, `xfer_kind` and all target operands have no effect on `next_pc`.
- R9: `next_pc` changes only at a rising clock edge and reflects the inputs sampled at that edge, which gives a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_en | input | 1 | High when a control transfer is requested this cycle |
| xfer_kind | input | 2 | Transfer kind: 00 absolute, 01 indirect, 10 extended indirect, 11 relative |
| cur_pc | input | 22 | Current word address |
| imm_tgt | input | 22 | Immediate target from the instruction |
| z_ptr | input | 16 | Z pointer contents |
| ext_hi | input | 8 | Extension byte placed above Z |
| rel_ofs | input | 12 | Signed relative displacement |
| next_pc | output | 22 | Registered next word address |

## Verification
The assertions assume that every input is at a known, stable value at each rising edge after reset. They also assume that `xfer_kind` is decoded only while `xfer_en` is high. The bench changes inputs only on the falling edge and always drives all operand buses, including those that the selected kind ignores. This lets random values in the unused operands expose any leakage. Constrained draws tilt the address and displacement toward the wrap boundaries and the extremes of the offset range.

// File: rtl/npc_pkg.sv
// Shared definitions for the next-PC selector.
// Assumes the 2-bit transfer-kind encoding is fixed by the decode stage.
package npc_pkg;
    typedef enum logic [1:0] {
        XFER_ABS = 2'b00,
        XFER_IND = 2'b01,
        XFER_EXT = 2'b10,
        XFER_REL = 2'b11
    } xfer_kind_t;
endpackage

// File: rtl/npc_targets.sv
// Computes every candidate next address in parallel: sequential step,
// zero-extended indirect, extension-over-Z indirect and relative.
// Assumes PC_W > Z_W and PC_W > OFS_W; all sums wrap modulo 2^PC_W.
module npc_targets #(
    parameter int PC_W  = 22,
    parameter int Z_W   = 16,
    parameter int EXT_W = 8,
    parameter int OFS_W = 12
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [Z_W-1:0]   z_i,
    input  logic [EXT_W-1:0] ext_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic [PC_W-1:0]  seq_o,
    output logic [PC_W-1:0]  ind_o,
    output logic [PC_W-1:0]  ext_o,
    output logic [PC_W-1:0]  rel_o
);
    localparam int CAT_W = EXT_W + Z_W;
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    logic [CAT_W-1:0] cat_w;
    logic [PC_W-1:0]  ofs_sext;

    // Join the extension register above Z.
    assign cat_w = {ext_i, z_i};

    // Sign-extend the displacement to the address width.
    assign ofs_sext = {{(PC_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};

    // Sequential step and relative target.
    assign seq_o = pc_i + ONE;
    assign rel_o = pc_i + ofs_sext + ONE;

    // Plain indirect target: Z zero-extended.
    assign ind_o = {{(PC_W-Z_W){1'b0}}, z_i};

    // Extended target: truncate or pad the joined value to the address width.
    generate
        if (CAT_W > PC_W) begin : g_ext_trunc
            logic [CAT_W-PC_W-1:0] ext_unused;
            assign ext_unused = cat_w[CAT_W-1:PC_W];
            assign ext_o = cat_w[PC_W-1:0];
        end else if (CAT_W == PC_W) begin : g_ext_exact
            assign ext_o = cat_w;
        end else begin : g_ext_pad
            assign ext_o = {{(PC_W-CAT_W){1'b0}}, cat_w};
        end
    endgenerate
endmodule

// File: rtl/npc_select.sv
// Picks one candidate address from the strobe and transfer kind.
// Assumes all candidates are valid every cycle; pure combinational.
module npc_select
    import npc_pkg::*;
#(
    parameter int PC_W = 22
) (
    input  logic            en_i,
    input  xfer_kind_t      kind_i,
    input  logic [PC_W-1:0] imm_i,
    input  logic [PC_W-1:0] seq_i,
    input  logic [PC_W-1:0] ind_i,
    input  logic [PC_W-1:0] ext_i,
    input  logic [PC_W-1:0] rel_i,
    output logic [PC_W-1:0] sel_o
);
    // Sequential step unless a transfer is requested; then decode the kind.
    always_comb begin
        sel_o = seq_i;
        if (en_i) begin
            unique case (kind_i)
                XFER_ABS: sel_o = imm_i;
                XFER_IND: sel_o = ind_i;
                XFER_EXT: sel_o = ext_i;
                XFER_REL: sel_o = rel_i;
                default:  sel_o = seq_i;
            endcase
        end
    end
endmodule

// File: rtl/npc_sel.sv
// Next program counter selector: registers the chosen next word address.
// Assumes synchronous active-low reset and inputs stable around the edge.
module npc_sel
    import npc_pkg::*;
#(
    parameter int PC_W  = 22,
    parameter int Z_W   = 16,
    parameter int EXT_W = 8,
    parameter int OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_en,
    input  logic [1:0]       xfer_kind,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PC_W-1:0]  imm_tgt,
    input  logic [Z_W-1:0]   z_ptr,
    input  logic [EXT_W-1:0] ext_hi,
    input  logic [OFS_W-1:0] rel_ofs,
    output logic [PC_W-1:0]  next_pc
);
    localparam int EXT_KEEP = (PC_W - Z_W < EXT_W) ? (PC_W - Z_W) : EXT_W;

    logic [PC_W-1:0] seq_w, ind_w, ext_w, rel_w, sel_w;
    xfer_kind_t      kind_w;

    assign kind_w = xfer_kind_t'(xfer_kind);

    npc_targets #(
        .PC_W(PC_W), .Z_W(Z_W), .EXT_W(EXT_W), .OFS_W(OFS_W)
    ) u_targets (
        .pc_i (cur_pc),
        .z_i  (z_ptr),
        .ext_i(ext_hi),
        .ofs_i(rel_ofs),
        .seq_o(seq_w),
        .ind_o(ind_w),
        .ext_o(ext_w),
        .rel_o(rel_w)
    );

    npc_select #(.PC_W(PC_W)) u_select (
        .en_i  (xfer_en),
        .kind_i(kind_w),
        .imm_i (imm_tgt),
        .seq_i (seq_w),
        .ind_i (ind_w),
        .ext_i (ext_w),
        .rel_i (rel_w),
        .sel_o (sel_w)
    );

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) next_pc <= '0;
        else        next_pc <= sel_w;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> next_pc == '0);  // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> next_pc == $past(cur_pc) + PC_W'(1));  // R2
    AST_ABS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && xfer_kind == 2'b00) |=> next_pc == $past(imm_tgt));  // R3
    AST_IND_ZERO_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && xfer_kind == 2'b01) |=>
            (next_pc[PC_W-1:Z_W] == '0 && next_pc[Z_W-1:0] == $past(z_ptr)));  // R4
    AST_EXT_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && xfer_kind == 2'b10) |=>
            (next_pc[Z_W-1:0] == $past(z_ptr) &&
             next_pc[Z_W+EXT_KEEP-1:Z_W] == $past(ext_hi[EXT_KEEP-1:0])));  // R5
    AST_REL_STAYS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && xfer_kind == 2'b11 && rel_ofs == '0) |=>
            next_pc == $past(cur_pc) + PC_W'(1));  // R6
endmodule

// File: tb/npc_sel_test.sv
module npc_sel_test;
    localparam int PC_W = 22;
    localparam logic [PC_W-1:0] MASK = {PC_W{1'b1}};

    logic             clk = 1'b0;
    logic             rst_n;
    logic             xfer_en;
    logic [1:0]       xfer_kind;
    logic [PC_W-1:0]  cur_pc, imm_tgt;
    logic [15:0]      z_ptr;
    logic [7:0]       ext_hi;
    logic [11:0]      rel_ofs;
    logic [PC_W-1:0]  next_pc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    npc_sel uut (
        .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .xfer_kind(xfer_kind),
        .cur_pc(cur_pc), .imm_tgt(imm_tgt), .z_ptr(z_ptr), .ext_hi(ext_hi),
        .rel_ofs(rel_ofs), .next_pc(next_pc)
    );

    function automatic logic [PC_W-1:0] model(
        input logic en, input logic [1:0] kind, input logic [PC_W-1:0] pc,
        input logic [PC_W-1:0] imm, input logic [15:0] z, input logic [7:0] ex,
        input logic [11:0] k);
        int signed ks;
        longint v;
        ks = int'($signed(k));
        if (!en) return (pc + 22'd1) & MASK;
        case (kind)
            2'b00: return imm;
            2'b01: return {6'd0, z};
            2'b10: return {ex[5:0], z};
            default: begin
                v = longint'(pc) + longint'(ks) + 64'sd1;
                return v[PC_W-1:0];
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [PC_W-1:0] exp);
        checks++;
        if (next_pc !== exp) begin
            failures++;
            $display("FAIL %s actual=%06h expected=%06h", req, next_pc, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
    task automatic apply(input string req, input logic en, input logic [1:0] kind,
                         input logic [PC_W-1:0] pc, input logic [PC_W-1:0] imm,
                         input logic [15:0] z, input logic [7:0] ex, input logic [11:0] k);
        @(negedge clk);
        xfer_en = en; xfer_kind = kind; cur_pc = pc; imm_tgt = imm;
        z_ptr = z; ext_hi = ex; rel_ofs = k;
        @(negedge clk);
        check(req, model(en, kind, pc, imm, z, ex, k));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; xfer_en = 1'b1; xfer_kind = 2'b00; cur_pc = 22'h12345;
        imm_tgt = 22'h2ABCDE; z_ptr = 16'hBEEF; ext_hi = 8'hFF; rel_ofs = 12'h7FF;
        repeat (3) @(negedge clk);
        check("R1 reset", '0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R9 first edge after reset", 22'h2ABCDE);

        apply("R2 step", 1'b0, 2'b11, 22'h000100, 22'h3FFFFF, 16'h1111, 8'h22, 12'h800);
        apply("R2 wrap", 1'b0, 2'b00, 22'h3FFFFF, 22'h0, 16'h0, 8'h0, 12'h0);
        apply("R8 kind ignored", 1'b0, 2'b10, 22'h001234, 22'h155555, 16'hFFFF, 8'hFF, 12'h7FF);
        apply("R3 absolute", 1'b1, 2'b00, 22'h000010, 22'h3A5A5A, 16'h0, 8'h0, 12'h0);
        apply("R4 indirect", 1'b1, 2'b01, 22'h3F0000, 22'h3FFFFF, 16'hCAFE, 8'hFF, 12'h0);
        apply("R5 extended", 1'b1, 2'b10, 22'h0, 22'h0, 16'h1234, 8'h2A, 12'h0);
        apply("R5 upper ext bits", 1'b1, 2'b10, 22'h0, 22'h0, 16'h1234, 8'hC0, 12'h0);
        apply("R6 relative", 1'b1, 2'b11, 22'h001000, 22'h0, 16'h0, 8'h0, 12'h005);
        apply("R7 min offset", 1'b1, 2'b11, 22'h001000, 22'h0, 16'h0, 8'h0, 12'h800);
        apply("R7 max offset", 1'b1, 2'b11, 22'h001000, 22'h0, 16'h0, 8'h0, 12'h7FF);
        apply("R6 wrap down", 1'b1, 2'b11, 22'h000002, 22'h0, 16'h0, 8'h0, 12'hFF0);
        apply("R6 wrap up", 1'b1, 2'b11, 22'h3FFFF0, 22'h0, 16'h0, 8'h0, 12'h020);

        // Mid-run reset must clear regardless of a pending transfer.
        @(negedge clk); rst_n = 1'b0; xfer_en = 1'b1; xfer_kind = 2'b00; imm_tgt = 22'h3FFFFF;
        @(negedge clk); check("R1 mid-run reset", '0);
        rst_n = 1'b1;

        for (int i = 0; i < 400; i++) begin
            logic [PC_W-1:0] pc;
            logic [11:0] k;
            pc = 22'($urandom);
            if ($urandom_range(3) == 0) pc = ($urandom_range(1)) ? (MASK - 22'($urandom_range(40))) : 22'($urandom_range(40));
            k = 12'($urandom);
            if ($urandom_range(3) == 0) k = ($urandom_range(1)) ? 12'h800 : 12'h7FF;
            apply("R6 R8 random", ($urandom_range(4) != 0), 2'($urandom), pc,
                  22'($urandom), 16'($urandom), 8'($urandom), k);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule